// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This block decides whether an integer trap instruction in a 64-bit pipeline stage should raise a trap. Each instruction supplies three things. The first is a five-bit condition mask. The second is a first register operand. The third is a second operand, taken either from a register or from a 16-bit signed immediate. The mask picks any mix of five relations between the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. The trap fires when at least one of the picked relations holds.

A size flag selects word or doubleword comparison. In word mode only the low 32 bits of each operand count, and each is sign-extended before comparison. A form flag picks the register or the immediate second operand. The result is registered. One cycle after an accepted input, the block presents a valid strobe together with the trap request for exactly one cycle.

Top module: `trap_eval`

## Requirements
- R1: Mask bit 4 (value 0x10) traps when operand A is less than operand B as signed numbers.
- R2: Mask bit 3 (value 0x08) traps when A is greater than B as signed numbers.
- R3: Mask bit 2 (value 0x04) traps when A equals B.
- R4: Mask bit 1 (value 0x02) traps when A is less than B as unsigned numbers.
- R5: Mask bit 0 (value 0x01) traps when A is greater than B as unsigned numbers.
- R6: The trap request is the OR of every relation whose mask bit is set.
- R7: With `use_imm` high, B is `imm` sign-extended from 16 bits, and `opnd_b` has no effect on the result.
- R8: With `is_word` high, both operands are replaced by their low 32 bits sign-extended to 64 bits, and the upper 32 bits of the inputs have no effect.
- R9: A mask of zero never raises a trap.
- R10: A mask of 0x1F always raises a trap.
- R11: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is high. `trap_req` is high only together with `out_valid`.
- R12: A synchronous active-high `rst` clears `out_valid` and `trap_req` at the next edge, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| cond_mask | input | 5 | Trap condition mask |
| is_word | input | 1 | 1: 32-bit compare, 0: 64-bit compare |
| use_imm | input | 1 | 1: B comes from imm, 0: from opnd_b |
| opnd_a | input | 64 | First register operand |
| opnd_b | input | 64 | Second register operand |
| imm | input | 16 | Signed immediate operand |
| out_valid | output | 1 | Registered result strobe |
| trap_req | output | 1 | Registered trap request |

## Verification
The assertions assume that the reset is held for at least one edge before any checks count. They also assume that the control and operand inputs never carry unknown values while `in_valid` is high. The bench meets both conditions: it holds reset at start and drives every input from defined values on the falling edge, including in idle cycles. It mixes directed operand pairs chosen to sit on sign and width boundaries with random masks and operands. It also interleaves idle cycles and a mid-stream reset, so the one-cycle strobe timing is exercised under back-to-back and sparse inputs.

// File: rtl/trap_eval_pkg.sv
package trap_eval_pkg;

  localparam int COND_W = 5;

  // Field order matches the mask bit order: slt is bit 4, ugt is bit 0.
  typedef struct packed {
    logic slt;
    logic sgt;
    logic eq;
    logic ult;
    logic ugt;
  } cmp_flags_t;

  localparam int BIT_SLT = 4;
  localparam int BIT_SGT = 3;
  localparam int BIT_EQ  = 2;
  localparam int BIT_ULT = 1;
  localparam int BIT_UGT = 0;

endpackage

// File: rtl/trap_operand_prep.sv
module trap_operand_prep #(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              is_word,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] a_cmp,
  output logic [DATA_W-1:0] b_cmp
);

  localparam int IMM_PAD  = DATA_W - IMM_W;
  localparam int WORD_PAD = DATA_W - WORD_W;

  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] a_narrow;
  logic [DATA_W-1:0] b_narrow;

  // Second operand: register or sign-extended immediate
  assign b_sel = use_imm ? {{IMM_PAD{imm[IMM_W-1]}}, imm} : opnd_b;

  // Word mode keeps the low half of each operand, sign-extended
  assign a_narrow = {{WORD_PAD{opnd_a[WORD_W-1]}}, opnd_a[WORD_W-1:0]};
  assign b_narrow = {{WORD_PAD{b_sel[WORD_W-1]}},  b_sel[WORD_W-1:0]};

  assign a_cmp = is_word ? a_narrow : opnd_a;
  assign b_cmp = is_word ? b_narrow : b_sel;

endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_eval_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a_cmp,
  input  logic [DATA_W-1:0] b_cmp,
  output cmp_flags_t        flags
);

  always_comb begin
    flags.slt = $signed(a_cmp) < $signed(b_cmp);
    flags.sgt = $signed(a_cmp) > $signed(b_cmp);
    flags.eq  = a_cmp == b_cmp;
    flags.ult = a_cmp < b_cmp;
    flags.ugt = a_cmp > b_cmp;
  end

  // Exactly one signed relation and exactly one unsigned relation hold (R10)
  always_comb begin
    if (!$isunknown({a_cmp, b_cmp})) begin
      a_r10_signed_trichotomy: assert ($countones({flags.slt, flags.sgt, flags.eq}) == 1)
        else $error("signed relations not exclusive");
      a_r10_unsigned_trichotomy: assert ($countones({flags.ult, flags.ugt, flags.eq}) == 1)
        else $error("unsigned relations not exclusive");
    end
  end

endmodule

// File: rtl/trap_eval.sv
module trap_eval
  import trap_eval_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [COND_W-1:0] cond_mask,
  input  logic              is_word,
  input  logic              use_imm,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  output logic              out_valid,
  output logic              trap_req
);

  logic [DATA_W-1:0] a_cmp;
  logic [DATA_W-1:0] b_cmp;
  cmp_flags_t        flags;
  logic              hit;

  trap_operand_prep #(
    .DATA_W(DATA_W),
    .WORD_W(WORD_W),
    .IMM_W (IMM_W)
  ) u_prep (
    .is_word(is_word),
    .use_imm(use_imm),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .imm    (imm),
    .a_cmp  (a_cmp),
    .b_cmp  (b_cmp)
  );

  trap_compare #(
    .DATA_W(DATA_W)
  ) u_cmp (
    .a_cmp(a_cmp),
    .b_cmp(b_cmp),
    .flags(flags)
  );

  // Enabled relations combined by OR
  assign hit = |(cond_mask & flags);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      trap_req  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      trap_req  <= in_valid & hit;
    end
  end

  a_r11_req_needs_valid: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> out_valid);

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_zero_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_mask == '0) |=> !trap_req);

  a_r10_full_mask_fires: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_mask == '1) |=> trap_req);

  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !trap_req));

endmodule

// File: tb/trap_eval_test.sv
module trap_eval_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [4:0]  cond_mask = '0;
  logic        is_word = 1'b0;
  logic        use_imm = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [15:0] imm = '0;
  logic        out_valid;
  logic        trap_req;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    pend_v   = 1'b0;
  bit    pend_t   = 1'b0;
  string pend_tag = "R12";
  bit    done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_eval uut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .cond_mask(cond_mask),
    .is_word  (is_word),
    .use_imm  (use_imm),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .imm      (imm),
    .out_valid(out_valid),
    .trap_req (trap_req)
  );

  // Behavioural reference model
  function automatic bit model_trap(input bit [4:0] m, input bit w, input bit fi,
                                    input bit [63:0] a, input bit [63:0] b,
                                    input bit [15:0] im);
    longint sa, sb;
    longint unsigned ua, ub;
    bit r;
    sa = longint'(a);
    sb = fi ? longint'(shortint'(im)) : longint'(b);
    if (w) begin
      sa = longint'(int'(sa[31:0]));
      sb = longint'(int'(sb[31:0]));
    end
    ua = longint'(sa);
    ub = longint'(sb);
    r = 1'b0;
    if (m[4] && (sa < sb)) r = 1'b1;
    if (m[3] && (sa > sb)) r = 1'b1;
    if (m[2] && (sa == sb)) r = 1'b1;
    if (m[1] && (ua < ub)) r = 1'b1;
    if (m[0] && (ua > ub)) r = 1'b1;
    return r;
  endfunction

  task automatic step(input bit r, input bit v, input bit [4:0] m, input bit w,
                      input bit fi, input bit [63:0] a, input bit [63:0] b,
                      input bit [15:0] im, input string tag);
    @(negedge clk);
    n_checks++;
    if (out_valid !== pend_v || trap_req !== pend_t) begin
      n_fail++;
      $display("FAIL %s: out_valid/trap_req actual %b/%b expected %b/%b",
               pend_tag, out_valid, trap_req, pend_v, pend_t);
    end
    rst = r; in_valid = v; cond_mask = m; is_word = w; use_imm = fi;
    opnd_a = a; opnd_b = b; imm = im;
    pend_v = !r && v;
    pend_t = !r && v && model_trap(m, w, fi, a, b, im);
    pend_tag = tag;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state check (R12)
    step(1, 0, 5'h00, 0, 0, 64'd0, 64'd0, 16'd0, "R12");
    // R1 signed less: -1 < 1 traps, 1 < -1 does not
    step(0, 1, 5'h10, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, "R1");
    step(0, 1, 5'h10, 0, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, "R1");
    // R2 signed greater
    step(0, 1, 5'h08, 0, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, "R2");
    step(0, 1, 5'h08, 0, 0, 64'd7, 64'd7, 16'd0, "R2");
    // R3 equal
    step(0, 1, 5'h04, 0, 0, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 16'd0, "R3");
    step(0, 1, 5'h04, 0, 0, 64'd3, 64'd4, 16'd0, "R3");
    // R4 unsigned less: 1 < 0xFFFF..
    step(0, 1, 5'h02, 0, 0, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, "R4");
    step(0, 1, 5'h02, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, "R4");
    // R5 unsigned greater
    step(0, 1, 5'h01, 0, 0, 64'h8000_0000_0000_0000, 64'd5, 16'd0, "R5");
    step(0, 1, 5'h01, 0, 0, 64'd5, 64'd5, 16'd0, "R5");
    // R6 combinations
    step(0, 1, 5'h12, 0, 0, 64'd9, 64'd2, 16'd0, "R6");
    step(0, 1, 5'h0C, 0, 0, 64'd2, 64'd2, 16'd0, "R6");
    // R7 immediate form, opnd_b ignored
    step(0, 1, 5'h04, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 16'hFFFE, "R7");
    step(0, 1, 5'h08, 0, 1, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8000, "R7");
    step(0, 1, 5'h01, 0, 1, 64'd100, 64'd0, 16'hFFFF, "R7");
    // R8 word mode, upper bits ignored
    step(0, 1, 5'h04, 1, 0, 64'hDEAD_BEEF_0000_0005, 64'h0000_0000_0000_0005, 16'd0, "R8");
    step(0, 1, 5'h04, 0, 0, 64'hDEAD_BEEF_0000_0005, 64'h0000_0000_0000_0005, 16'd0, "R8");
    step(0, 1, 5'h10, 1, 0, 64'h0000_0000_8000_0000, 64'd1, 16'd0, "R8");
    step(0, 1, 5'h01, 1, 1, 64'h0000_0000_8000_0000, 64'hFFFF, 16'h0005, "R8");
    // R9 zero mask
    step(0, 1, 5'h00, 0, 0, 64'd1, 64'd2, 16'd0, "R9");
    step(0, 1, 5'h00, 1, 1, 64'd0, 64'd0, 16'd0, "R9");
    // R10 all-ones mask
    step(0, 1, 5'h1F, 0, 0, 64'd4, 64'd4, 16'd0, "R10");
    step(0, 1, 5'h1F, 1, 1, 64'hFFFF_0000_0000_0000, 64'd0, 16'h7FFF, "R10");
    // R11 idle cycles produce no strobe
    step(0, 0, 5'h1F, 0, 0, 64'd1, 64'd1, 16'd0, "R11");
    step(0, 0, 5'h1F, 0, 0, 64'd1, 64'd1, 16'd0, "R11");
    step(0, 1, 5'h1F, 0, 0, 64'd1, 64'd1, 16'd0, "R11");
    // R12 reset while valid
    step(1, 1, 5'h1F, 0, 0, 64'd1, 64'd1, 16'd0, "R12");
    step(0, 0, 5'h00, 0, 0, 64'd0, 64'd0, 16'd0, "R12");
    // Random mix (R6)
    for (int i = 0; i < 400; i++) begin
      bit [63:0] ra, rb;
      bit [15:0] ri;
      ra = {$urandom, $urandom};
      rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom};
      ri = 16'($urandom);
      if ($urandom_range(0, 3) == 0) ra = 64'(longint'(shortint'(ri)));
      step(0, 1'($urandom_range(0, 4) != 0), 5'($urandom), 1'($urandom),
           1'($urandom), ra, rb, ri, "R6");
    end
    step(0, 0, 5'h00, 0, 0, 64'd0, 64'd0, 16'd0, "R11");
    step(0, 0, 5'h00, 0, 0, 64'd0, 64'd0, 16'd0, "R11");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule